// File: doc/BRIEF.md
# Replayable Queue with Occupancy Flags

This block is a single-clock first-in first-out queue of `DEPTH` words of `DATA_W` bits (2048 by 9 by default). Words are pushed with a one-cycle write request and popped with a one-cycle read request, and they leave in the order they arrived. No address is supplied from outside. Three active-low flags report the number of unread words: empty, more than half full, and full.

A replay request moves the read position back to storage location zero and leaves the write position alone. Everything written since the last reset can then be read again, as often as needed. The block assumes the write position has not wrapped more than once since reset. A popped word is presented for one cycle together with an output-enable indication. That indication stays low whenever no read was accepted, which includes every read request made while the queue is empty.

Top module: `rtfifo_retx`

## Requirements
- R1: Words are read out in the same order as they were accepted for writing.
- R2: While `rst_n` is low at a clock edge, both positions return to location zero. After that edge `empty_n` is 0, `half_n` and `full_n` are 1, `rd_oe` is 0, and no earlier word is reachable.
- R3: The flags depend on the unread count N. At N = 0 only `empty_n` is 0. For 1 ≤ N ≤ DEPTH/2 all three flags are 1. For DEPTH/2 < N < DEPTH only `half_n` is 0. At N = DEPTH both `half_n` and `full_n` are 0. Flags reflect a request from the edge at which it is sampled.
- R4: A write request made while the queue holds DEPTH words is ignored. The count does not change and the word is never read out.
- R5: A read request made while the queue holds no words is ignored. `rd_oe` stays 0 and the count does not change.
- R6: An accepted replay request sets the read position to location zero and leaves the write position unchanged. N becomes the write position, or DEPTH when the write position has wrapped back to zero, and the flags follow the new N.
- R7: Replay can be repeated any number of times. A full block of DEPTH words can be replayed, and the full flag is then asserted again.
- R8: A replay request is accepted only in a cycle with neither a read nor a write request. Otherwise it is ignored and the other requests act normally.
- R9: `rd_oe` is 1 in the cycle after an accepted read, and only then. `rd_data` holds the popped word in that cycle.
- R10: When read and write are requested together with 0 < N < DEPTH, both take effect and N is unchanged. With N = 0 only the write takes effect. With N = DEPTH only the read takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_req | input | 1 | One-cycle write request |
| wr_data | input | DATA_W | Word to write |
| rd_req | input | 1 | One-cycle read request |
| rt_req | input | 1 | One-cycle replay request |
| rd_data | output | DATA_W | Popped word, valid while rd_oe is 1 |
| rd_oe | output | 1 | Output enable for rd_data |
| full_n | output | 1 | Low when DEPTH words are held |
| half_n | output | 1 | Low when more than DEPTH/2 words are held |
| empty_n | output | 1 | Low when no word is held |

## Verification
The bench builds the queue with DEPTH = 16 and DATA_W = 9. At that size it can step through every count from 0 to 16 in both directions and check all three flags at each step, including both sides of the half threshold at 8 and 9. The small depth also lets it reach wrap-around of the write position, and replay of a complete 16-word block, within a few hundred cycles. Expected words and flags come from an arithmetic queue model in the bench. That model covers the simultaneous-request and ignored-request rules.

// File: rtl/rtfifo_pkg.sv
// Shared types and the flag decode for the replayable queue.
// Assumes the flags are active-low and the half threshold is DEPTH/2.
package rtfifo_pkg;

    typedef struct packed {
        logic full_n;
        logic half_n;
        logic empty_n;
    } occ_flags_t;

    // Decode an unread-word count into the three active-low flags.
    function automatic occ_flags_t flags_of(input int unsigned cnt,
                                            input int unsigned depth);
        occ_flags_t f;
        f.empty_n = (cnt != 0);
        f.half_n  = !(cnt > depth / 2);
        f.full_n  = (cnt != depth);
        return f;
    endfunction

endpackage

// File: rtl/rtfifo_ctrl.sv
// Pointer and occupancy control. Decides which requests are accepted,
// advances the write and read positions modulo DEPTH, and keeps the
// unread count. Assumes DEPTH is a power of two and that the write
// position wraps at most once before a replay.
module rtfifo_ctrl #(
    parameter int DEPTH = 2048,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic          rd_req,
    input  logic          rt_req,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic [CW-1:0] count
);

    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          lap_q;
    logic          rt_ok;
    logic [CW-1:0] rt_count;

    // Acceptance of each request against the current count.
    always_comb begin
        wr_en = wr_req && (cnt_q != CW'(DEPTH));
        rd_en = rd_req && (cnt_q != '0);
        rt_ok = rt_req && !wr_req && !rd_req;
    end

    // Count implied by a replay: the write position, or a full block.
    always_comb begin
        if (wp_q == '0 && lap_q)
            rt_count = CW'(DEPTH);
        else
            rt_count = {1'b0, wp_q};
    end

    // Write position and its lap marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            lap_q <= 1'b0;
        end else if (wr_en) begin
            wp_q <= wp_q + 1'b1;
            if (wp_q == '1)
                lap_q <= 1'b1;
        end
    end

    // Read position, rewound to zero on replay.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rp_q <= '0;
        else if (rt_ok)
            rp_q <= '0;
        else if (rd_en)
            rp_q <= rp_q + 1'b1;
    end

    // Unread count, reloaded on replay, stepped otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (rt_ok)
            cnt_q <= rt_count;
        else begin
            case ({wr_en, rd_en})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign wr_addr = wp_q;
    assign rd_addr = rp_q;
    assign count   = cnt_q;

endmodule

// File: rtl/rtfifo_store.sv
// Word storage with a registered read port and output-enable register.
// Assumes a read and a write never target the same address in one cycle,
// which holds because a read is only accepted when the queue is not empty.
module rtfifo_store #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 2048,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_oe
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_q;

    // Array write; no reset so the array maps onto RAM.
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_addr] <= wr_data;
    end

    // Registered read of the word at the read position.
    always_ff @(posedge clk) begin
        if (rd_en)
            rd_q <= mem[rd_addr];
    end

    // Output enable for one cycle after each accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_oe <= 1'b0;
        else
            rd_oe <= rd_en;
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/rtfifo_flags.sv
// Flag decode from the registered unread count. Purely combinational,
// so each flag settles in the cycle after the request that moved it.
module rtfifo_flags #(
    parameter int DEPTH = 2048,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic [CW-1:0] count,
    output logic          full_n,
    output logic          half_n,
    output logic          empty_n
);
    import rtfifo_pkg::*;

    occ_flags_t f;

    // Threshold compares against the parameterised depth.
    always_comb begin
        f       = flags_of(int'(count), DEPTH);
        full_n  = f.full_n;
        half_n  = f.half_n;
        empty_n = f.empty_n;
    end

endmodule

// File: rtl/rtfifo_retx.sv
// Top of the replayable queue: control, storage and flag decode.
// Assumes request inputs are single-cycle pulses synchronous to clk.
module rtfifo_retx #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_req,
    input  logic              rt_req,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_oe,
    output logic              full_n,
    output logic              half_n,
    output logic              empty_n
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic          wr_en, rd_en;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [CW-1:0] count;

    rtfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_req  (wr_req),
        .rd_req  (rd_req),
        .rt_req  (rt_req),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .count   (count)
    );

    rtfifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .rd_oe   (rd_oe)
    );

    rtfifo_flags #(.DEPTH(DEPTH)) u_flags (
        .count   (count),
        .full_n  (full_n),
        .half_n  (half_n),
        .empty_n (empty_n)
    );

endmodule

// File: rtl/rtfifo_retx_chk.sv
// Port-level checker for the replayable queue, bound to every instance.
module rtfifo_retx_chk #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 2048
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_req,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_req,
    input logic              rt_req,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_oe,
    input logic              full_n,
    input logic              half_n,
    input logic              empty_n
);

    logic rst_seen_q;

    // Remembers whether the previous edge was in reset.
    always_ff @(posedge clk) rst_seen_q <= rst_n;

    AST_RESET_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_seen_q |-> (!empty_n && full_n && half_n && !rd_oe)); // R2

    AST_FULL_IMPLIES_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        !full_n |-> (!half_n && empty_n)); // R3

    AST_HALF_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !half_n |-> empty_n); // R3

    AST_FULL_HOLDS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && wr_req && !rd_req && !rt_req) |=> !full_n); // R4

    AST_EMPTY_READ_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n && rd_req) |=> !rd_oe); // R5

    AST_OE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && empty_n) |=> rd_oe); // R9

    AST_OE_ONLY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_oe |-> ($past(rd_req) && $past(empty_n))); // R9

    AST_BOTH_KEEP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && wr_req && empty_n && full_n) |=> $stable({full_n, half_n, empty_n})); // R10

    AST_BOTH_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && wr_req && !empty_n) |=> (empty_n && !rd_oe)); // R10

endmodule

bind rtfifo_retx rtfifo_retx_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_rtfifo_retx.sv
module tb_rtfifo_retx;
    localparam int DW    = 9;
    localparam int DEPTH = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_req = 1'b0, rd_req = 1'b0, rt_req = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          rd_oe, full_n, half_n, empty_n;

    int checks = 0, errors = 0;
    bit done = 0;

    // Reference queue state
    logic [DW-1:0] m_mem [DEPTH];
    int m_wp, m_rp, m_cnt;
    bit m_lap;
    int seq = 0;

    always #10 clk = ~clk;

    rtfifo_retx #(.DATA_W(DW), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_data(wr_data),
        .rd_req(rd_req), .rt_req(rt_req), .rd_data(rd_data), .rd_oe(rd_oe),
        .full_n(full_n), .half_n(half_n), .empty_n(empty_n));

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_flags(input string tag);
        chk({tag, " empty_n"}, int'(empty_n), int'(m_cnt != 0));
        chk({tag, " half_n"},  int'(half_n),  int'(!(m_cnt > DEPTH / 2)));
        chk({tag, " full_n"},  int'(full_n),  int'(m_cnt != DEPTH));
    endtask

    function automatic logic [DW-1:0] pat();
        seq++;
        return DW'((seq * 37 + 5) % 512);
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        m_wp = 0; m_rp = 0; m_cnt = 0; m_lap = 0;
        chk_flags("R2");
        chk("R2 rd_oe", int'(rd_oe), 0);
    endtask

    // One cycle of requests; updates the model and checks all outputs.
    task automatic op(input bit w, input logic [DW-1:0] d, input bit r,
                      input bit t, input string tag);
        bit wok, rok, tok;
        logic [DW-1:0] exp_d;
        wok = w && (m_cnt != DEPTH);
        rok = r && (m_cnt != 0);
        tok = t && !w && !r;
        exp_d = m_mem[m_rp];
        if (wok) begin
            m_mem[m_wp] = d;
            if (m_wp == DEPTH - 1) m_lap = 1;
            m_wp = (m_wp + 1) % DEPTH;
        end
        if (tok) begin
            m_rp = 0;
            m_cnt = (m_wp == 0 && m_lap) ? DEPTH : m_wp;
        end else begin
            if (rok) m_rp = (m_rp + 1) % DEPTH;
            m_cnt = m_cnt + int'(wok) - int'(rok);
        end
        wr_req = w; wr_data = d; rd_req = r; rt_req = t;
        @(negedge clk);
        wr_req = 0; rd_req = 0; rt_req = 0;
        chk({tag, " R9 rd_oe"}, int'(rd_oe), int'(rok));
        if (rok) chk({tag, " R1 data"}, int'(rd_data), int'(exp_d));
        chk_flags({tag, " R3"});
    endtask

    initial begin
        #(20ns * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // Fill through every count, one write past full, then drain.
        for (int i = 0; i < DEPTH; i++) op(1, pat(), 0, 0, "R3 fill");
        op(1, 9'h1AA, 0, 0, "R4 write-when-full");
        for (int i = 0; i < DEPTH; i++) op(0, '0, 1, 0, "R1 drain");
        op(0, '0, 1, 0, "R5 read-when-empty");
        chk("R5 count stays zero", int'(empty_n), 0);

        // Partial block replay, repeated, and blocked replays.
        do_reset();
        for (int i = 0; i < 10; i++) op(1, pat(), 0, 0, "R6 load");
        for (int i = 0; i < 4; i++)  op(0, '0, 1, 0, "R6 pre-read");
        op(0, '0, 0, 1, "R6 replay");
        for (int i = 0; i < 10; i++) op(0, '0, 1, 0, "R6 reread");
        op(0, '0, 0, 1, "R7 replay again");
        for (int i = 0; i < 2; i++)  op(0, '0, 1, 0, "R7 reread");
        op(0, '0, 1, 1, "R8 replay with read");
        op(1, pat(), 0, 1, "R8 replay with write");
        op(0, '0, 1, 0, "R8 next word");
        chk("R8 rewind not taken", int'(m_rp), 4);

        // Simultaneous requests at empty, mid level and full.
        do_reset();
        op(1, pat(), 1, 0, "R10 both on empty");
        for (int i = 0; i < 4; i++) op(1, pat(), 0, 0, "R10 load");
        for (int i = 0; i < 6; i++) op(1, pat(), 1, 0, "R10 both mid");
        while (m_cnt < DEPTH) op(1, pat(), 0, 0, "R10 fill");
        op(1, 9'h155, 1, 0, "R10 both on full");
        while (m_cnt > 0) op(0, '0, 1, 0, "R10 drain");

        // Full-block replay after the write position wraps.
        do_reset();
        for (int i = 0; i < DEPTH; i++) op(1, pat(), 0, 0, "R7 full load");
        for (int i = 0; i < 5; i++)     op(0, '0, 1, 0, "R7 partial");
        op(0, '0, 0, 1, "R7 full replay");
        chk("R7 full again", int'(full_n), 0);
        for (int i = 0; i < DEPTH; i++) op(0, '0, 1, 0, "R7 full reread");

        // Reset in mid use discards content.
        for (int i = 0; i < 3; i++) op(1, pat(), 0, 0, "R2 preload");
        do_reset();
        op(0, '0, 1, 0, "R2 nothing reachable");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule